// File: doc/BRIEF.md
# LRU Stack Depth Profiler

This block models the tag state of a set-associative cache with strict least-recently-used replacement. For each access it records where the line stood in its set's recency order. Every set keeps one saturating counter for each recency position, plus one counter for misses. Together these counters form a per-set histogram of reuse depth. The block does not fetch or write any data. It holds only its own tag model and its own counters.

Addresses arrive one per cycle, qualified by a valid strobe and accepted while the ready output is high. After the counter update, the accessed line becomes the most recent entry of its set. On a miss, the oldest entry is dropped and the new tag enters at the top. A registered read port returns any one counter of any set one cycle after it is addressed. A synchronous clear input empties every recency stack and zeroes every counter, which starts a new profiling interval.

Top module: `lru_depth_profiler`

## Requirements
- R1: The address is split from the least significant end into OFFSET_W offset bits, SET_W set-index bits and ADDR_W-SET_W-OFFSET_W tag bits. The offset bits do not affect the outcome of an access.
- R2: An access whose tag is found at recency position p adds one to bin p-1 of that set. Position 1 is the most recently used line and position WAYS is the least recently used line.
- R3: An access whose tag is absent from its set adds one to bin WAYS of that set, which is the miss bin.
- R4: After an access, its tag is at position 1. Entries that were above it move down by one position, and entries below it keep their positions.
- R5: A miss to a set that holds WAYS valid lines evicts the line at position WAYS. A later access to the evicted tag is a miss.
- R6: An access changes neither the counters nor the recency stack of any other set.
- R7: Each counter saturates at 2^CNT_W-1. Further increments leave it at that value.
- R8: While clear is high, acc_ready is low and no access is accepted. One cycle after clear, every counter reads zero and every stack is empty.
- R9: The value of counter (rd_set, rd_bin) appears on rd_count on the clock edge after the address is presented. A bin index greater than WAYS returns zero.
- R10: While no counter of a set has saturated, the sum of that set's WAYS+1 bins equals the number of accesses accepted for that set.
- R11: After reset, every counter reads zero, every stack is empty and acc_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous profile clear (counters and stacks) |
| acc_valid | input | 1 | Access address is valid |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| rd_set | input | SET_W | Set selected for readout |
| rd_bin | input | BIN_W | Bin selected for readout (0..WAYS-1 hit positions, WAYS miss) |
| rd_count | output | CNT_W | Selected counter value, one cycle later |

## Verification
Some properties are checked on every cycle. In each stack, at most one entry matches the incoming tag. An accepted access leaves its tag valid at the top of the stack. A hit keeps the number of valid entries the same, and a miss to a set that is not full adds exactly one entry. Counters never decrease unless clear is applied, they hold at their maximum, and they read zero after a clear. Out-of-range reads return zero, and ready stays low during clear. Other behaviour can only be shown by the bench's scenarios, which compare counters against an independent recency model. These cover exact bin selection for each depth, eviction order, isolation between sets, that offset bits are ignored, the histogram sum, and the full clear sequence.

// File: rtl/lrup_pkg.sv
package lrup_pkg;
  // Outcome of one accepted access, exposed for checking.
  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_HIT  = 2'd1,
    EV_MISS = 2'd2
  } lrup_event_e;
endpackage

// File: rtl/lrup_set_stack.sv
module lrup_set_stack #(
  parameter int TAG_W = 28,
  parameter int WAYS  = 4,
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit,
  output logic [POS_W-1:0] hit_pos
);
  // Index 0 is the most recently used entry.
  logic [TAG_W-1:0] tags [WAYS];
  logic [WAYS-1:0]  vld;
  logic [WAYS-1:0]  match;
  logic [POS_W-1:0] shift_lim;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tags[w] == tag_in);
  end

  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) hit_pos = POS_W'(i);
    end
  end

  assign hit       = |match;
  // Entries at or above this index shift down by one.
  assign shift_lim = hit ? hit_pos : POS_W'(WAYS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      vld <= '0;
      for (int i = 0; i < WAYS; i++) tags[i] <= '0;
    end else if (upd_en) begin
      tags[0] <= tag_in;
      vld[0]  <= 1'b1;
      for (int i = 1; i < WAYS; i++) begin
        if (POS_W'(i) <= shift_lim) begin
          tags[i] <= tags[i-1];
          vld[i]  <= vld[i-1];
        end
      end
    end
  end

  // Tags in a set are unique, so at most one entry matches (R4).
  assert_unique_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // The accessed tag sits valid at the top afterwards (R4).
  assert_mru_after_access_R4: assert property (@(posedge clk) disable iff (!rst_n || clear)
    upd_en |=> vld[0] && (tags[0] == $past(tag_in)));

  // A hit only reorders, so the count of valid lines is unchanged (R4).
  assert_hit_keeps_fill_R4: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (upd_en && hit) |=> $countones(vld) == $countones($past(vld)));

  // A miss into a set that is not full grows it by exactly one line (R5).
  assert_miss_grows_R5: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (upd_en && !hit && !vld[WAYS-1]) |=> $countones(vld) == $countones($past(vld)) + 1);
endmodule

// File: rtl/lrup_hist_bank.sv
module lrup_hist_bank #(
  parameter int SETS  = 4,
  parameter int BINS  = 5,
  parameter int CNT_W = 8,
  parameter int SET_W = 2,
  parameter int BIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump_en,
  input  logic [SET_W-1:0] bump_set,
  input  logic [BIN_W-1:0] bump_bin,
  input  logic [SET_W-1:0] rd_set,
  input  logic [BIN_W-1:0] rd_bin,
  output logic [CNT_W-1:0] rd_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt [SETS][BINS];

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar b = 0; b < BINS; b++) begin : g_bin
      logic hit_me;
      assign hit_me = bump_en && (bump_set == SET_W'(s)) && (bump_bin == BIN_W'(b));

      always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt[s][b] <= '0;
        else if (hit_me)     cnt[s][b] <= sat_inc(cnt[s][b]);
      end

      // Counters only move up between clears (R10).
      assert_no_decrease_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> cnt[s][b] >= $past(cnt[s][b]));

      // A full counter stays full (R7).
      assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && cnt[s][b] == CNT_MAX) |=> cnt[s][b] == CNT_MAX);

      // Clear empties the counter (R8).
      assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt[s][b] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)                rd_count <= '0;
    else if (rd_bin < BIN_W'(BINS))     rd_count <= cnt[rd_set][rd_bin];
    else                                rd_count <= '0;
  end

  // Out-of-range bins read as zero (R9).
  assert_bad_bin_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bin >= BIN_W'(BINS)) |=> rd_count == '0);
endmodule

// File: rtl/lru_depth_profiler.sv
module lru_depth_profiler #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 2,
  parameter int SET_W    = 2,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 8,
  localparam int BIN_W   = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [BIN_W-1:0]  rd_bin,
  output logic [CNT_W-1:0]  rd_count
);
  import lrup_pkg::*;

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W - OFFSET_W;
  localparam int BINS  = WAYS + 1;
  localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFFSET_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic              accept;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag_val;
  logic [SETS-1:0]   set_hit;
  logic [POS_W-1:0]  set_pos [SETS];
  logic              sel_hit;
  logic [POS_W-1:0]  sel_pos;
  logic [BIN_W-1:0]  bump_bin;
  lrup_event_e       acc_event;

  assign acc_ready = !clear;
  assign accept    = acc_valid && acc_ready;
  assign set_idx   = addr_set(acc_addr);
  assign tag_val   = addr_tag(acc_addr);

  for (genvar s = 0; s < SETS; s++) begin : g_stack
    lrup_set_stack #(.TAG_W(TAG_W), .WAYS(WAYS), .POS_W(POS_W)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .upd_en  (accept && (set_idx == SET_W'(s))),
      .tag_in  (tag_val),
      .hit     (set_hit[s]),
      .hit_pos (set_pos[s])
    );
  end

  assign sel_hit   = set_hit[set_idx];
  assign sel_pos   = set_pos[set_idx];
  assign bump_bin  = sel_hit ? BIN_W'(sel_pos) : BIN_W'(WAYS);
  assign acc_event = !accept ? EV_IDLE : (sel_hit ? EV_HIT : EV_MISS);

  lrup_hist_bank #(
    .SETS(SETS), .BINS(BINS), .CNT_W(CNT_W), .SET_W(SET_W), .BIN_W(BIN_W)
  ) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .bump_en  (accept),
    .bump_set (set_idx),
    .bump_bin (bump_bin),
    .rd_set   (rd_set),
    .rd_bin   (rd_bin),
    .rd_count (rd_count)
  );

  // No access is taken while clearing (R8).
  assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !acc_ready && (acc_event == EV_IDLE));

  // A miss always lands in the miss bin (R3).
  assert_miss_bin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_event == EV_MISS) |-> bump_bin == BIN_W'(WAYS));
endmodule

// File: tb/test_lru_depth_profiler.sv
`timescale 1ns/1ps
module test_lru_depth_profiler;
  localparam int ADDR_W = 32, OFFSET_W = 2, SET_W = 2, WAYS = 4, CNT_W = 8;
  localparam int BIN_W = 3, SETS = 4, BINS = WAYS + 1, CMAX = 255;

  logic clk = 0, rst_n = 0, clear = 0, acc_valid = 0;
  logic acc_ready;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [SET_W-1:0]  rd_set = '0;
  logic [BIN_W-1:0]  rd_bin = '0;
  logic [CNT_W-1:0]  rd_count;

  int checks = 0, failures = 0;
  int mstk [SETS][WAYS];
  int mlen [SETS];
  int mcnt [SETS][BINS];
  int macc [SETS];

  always #2.5 clk = ~clk;

  lru_depth_profiler #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SET_W(SET_W),
                       .WAYS(WAYS), .CNT_W(CNT_W)) i_lru_depth_profiler (
    .clk(clk), .rst_n(rst_n), .clear(clear), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_addr(acc_addr), .rd_set(rd_set),
    .rd_bin(rd_bin), .rd_count(rd_count));

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
    return {tag[27:0], set[1:0], off[1:0]};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      mlen[s] = 0; macc[s] = 0;
      for (int b = 0; b < BINS; b++) mcnt[s][b] = 0;
    end
  endtask

  // Independent recency model: search, then move to the front.
  task automatic model_access(input int set, input int tag);
    int found = -1;
    int last;
    for (int i = 0; i < mlen[set]; i++) if (mstk[set][i] == tag) found = i;
    if (found >= 0) begin
      if (mcnt[set][found] < CMAX) mcnt[set][found]++;
      last = found;
    end else begin
      if (mcnt[set][WAYS] < CMAX) mcnt[set][WAYS]++;
      if (mlen[set] < WAYS) mlen[set]++;
      last = mlen[set] - 1;
    end
    for (int i = last; i > 0; i--) mstk[set][i] = mstk[set][i-1];
    mstk[set][0] = tag;
    macc[set]++;
  endtask

  task automatic access(input int tag, input int set, input int off);
    @(negedge clk);
    acc_addr = mk(tag, set, off);
    acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    model_access(set, tag);
  endtask

  task automatic read_cnt(input int set, input int bin, output int val);
    @(negedge clk);
    rd_set = SET_W'(set);
    rd_bin = BIN_W'(bin);
    @(posedge clk);
    #1 val = int'(rd_count);
  endtask

  task automatic check_set(input string req, input int set);
    int v;
    for (int b = 0; b < BINS; b++) begin
      read_cnt(set, b, v);
      check(req, v, mcnt[set][b]);
    end
  endtask

  task automatic t_reset();   // R11
    int v;
    check("R11 ready after reset", int'(acc_ready), 1);
    for (int s = 0; s < SETS; s++) check_set("R11 counters zero", s);
    read_cnt(0, WAYS, v);
    check("R11 miss bin zero", v, 0);
  endtask

  task automatic t_depths();  // R2 R3 R4
    int v;
    access(10, 1, 0); access(11, 1, 0); access(12, 1, 0); access(13, 1, 0);
    read_cnt(1, WAYS, v); check("R3 four cold misses", v, 4);
    access(13, 1, 0);                     // stack 13 12 11 10, pos 1
    read_cnt(1, 0, v); check("R2 hit at position 1 -> bin 0", v, 1);
    access(10, 1, 0);                     // pos 4
    read_cnt(1, 3, v); check("R2 hit at position 4 -> bin 3", v, 1);
    access(11, 1, 0);                     // stack 10 13 12 11 -> pos 4
    read_cnt(1, 3, v); check("R4 shift moves 11 to bottom", v, 2);
    access(13, 1, 0);                     // stack 11 10 13 12 -> pos 3
    read_cnt(1, 2, v); check("R4 entry below hit keeps position", v, 1);
    check_set("R2 R4 full set compare", 1);
  endtask

  task automatic t_evict();   // R5
    int v;
    access(20, 1, 0);                     // full set: evicts 12
    access(12, 1, 0);
    read_cnt(1, WAYS, v); check("R5 evicted tag misses again", v, 6);
    check_set("R5 set compare", 1);
  endtask

  task automatic t_offset();  // R1
    int v;
    access(12, 1, 3);
    read_cnt(1, 0, v); check("R1 offset bits ignored, hit at position 1", v, 2);
  endtask

  task automatic t_isolate(); // R6
    access(12, 2, 0);
    check_set("R6 other set untouched", 1);
    check_set("R6 same tag other set misses", 2);
    check_set("R6 idle set zero", 0);
  endtask

  task automatic t_read();    // R9
    int v;
    for (int b = WAYS + 1; b < 8; b++) begin
      read_cnt(1, b, v); check("R9 out-of-range bin reads zero", v, 0);
    end
    @(negedge clk); rd_set = 1; rd_bin = 0;
    @(posedge clk); #1 check("R9 one-cycle read latency", int'(rd_count), 2);
  endtask

  task automatic t_sum();     // R10
    int v, sum;
    sum = 0;
    for (int b = 0; b < BINS; b++) begin read_cnt(1, b, v); sum += v; end
    check("R10 histogram sum equals accesses", sum, macc[1]);
  endtask

  task automatic t_sat();     // R7
    int v;
    for (int i = 0; i < 260; i++) access(5, 3, 0);
    read_cnt(3, 0, v); check("R7 hit counter saturates", v, CMAX);
    read_cnt(3, WAYS, v); check("R7 miss bin unaffected", v, 1);
  endtask

  task automatic t_clear();   // R8
    int v;
    @(negedge clk);
    clear = 1; acc_valid = 1; acc_addr = mk(12, 1, 0);
    #1 check("R8 ready low during clear", int'(acc_ready), 0);
    @(negedge clk);
    clear = 0; acc_valid = 0;
    model_reset();
    for (int s = 0; s < SETS; s++) check_set("R8 counters cleared", s);
    access(12, 1, 0);
    read_cnt(1, WAYS, v); check("R8 stack emptied, old tag misses", v, 1);
    read_cnt(1, 0, v); check("R8 access during clear ignored", v, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_depths();
    t_evict();
    t_offset();
    t_isolate();
    t_read();
    t_sum();
    t_sat();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule